// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block is the arithmetic and logic stage of a small processor datapath together with the processor status word that the stage maintains. It has two operands, a three-bit opcode and a size select that picks between byte and word operation. From these it produces a result combinationally and a set of six condition flags: carry, parity, half carry, zero, sign and overflow. The condition flags are loaded into a 16-bit flags register on the clock edge when the execute strobe is high.

The same register also holds three control flags: single-step trap, interrupt enable and string direction. These change only through a dedicated write port that selects one control flag and gives it a value. ALU results never change them. The bits of the register that carry no flag always read back a fixed pattern.

Downstream logic uses the result in the same cycle and the registered flags from the next cycle onward. This matches the way a conditional branch reads flags that an earlier instruction produced.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract a minus b), 5 (increment a) and 6 (decrement a) return their result modulo the active width, which is 8 bits when byte_mode is 1 and 16 bits otherwise. In byte mode, bits 15:8 of the result are always zero.
- R2: Opcodes 2 (AND), 3 (OR) and 4 (XOR) return the bitwise result. An executed logic operation clears CF (bit 0), AF (bit 4) and OF (bit 11).
- R3: For add and subtract, CF is the carry out of the active width's top bit, or the borrow in the case of subtract. Increment and decrement leave CF at its previous value.
- R4: For arithmetic operations, OF (bit 11) is set exactly when the signed two's-complement result does not fit in the active width.
- R5: SF (bit 7) equals the top bit of the active width of the result (bit 7 in byte mode, bit 15 in word mode). ZF (bit 6) is set when the result over the active width is zero.
- R6: For arithmetic operations, AF (bit 4) is set on a carry out of bit 3, or on a borrow into bit 3 for subtract and decrement.
- R7: PF (bit 2) is set when bits 7:0 of the result hold an even number of ones, in both byte and word mode.
- R8: The six condition flags load only on a clock edge with exec high and an opcode other than 7. Opcode 7 passes operand a through as the result and leaves every flag unchanged.
- R9: When ctl_we is high, ctl_val is written to the flag picked by ctl_sel: 0 selects TF (bit 8), 1 selects IF (bit 9) and 2 selects DF (bit 10). ctl_sel 3 writes nothing. ALU operations never alter these three bits.
- R10: Reset (rst_n low) clears every flag. Bit 1 always reads 1, and bits 3, 5 and 15:12 always read 0, so the reset value is 16'h0002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (unused by increment, decrement and pass) |
| opcode | input | 3 | Operation select, encoded as listed in R1, R2 and R8 |
| byte_mode | input | 1 | 1 = operate on bits 7:0, 0 = operate on all 16 bits |
| exec | input | 1 | Load the condition flags from this cycle's operation |
| ctl_we | input | 1 | Write one control flag |
| ctl_sel | input | 2 | Control flag select for ctl_we |
| ctl_val | input | 1 | Value written to the selected control flag |
| result | output | 16 | Combinational ALU result |
| flags | output | 16 | Registered flags word |

## Verification
A fault in the carry chain shows on the result lines in the same cycle. It also shows in CF, OF or AF one edge later. A stale or wrongly held flag bit shows only at the flags output. It appears on the first edge where an executed operation or a control write should have changed that bit, or where a held bit should have stayed unchanged. For that reason, every cycle compares the full flags word against a behavioural model that carries the previous carry forward. This exposes any fault in how increment and decrement keep CF.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_INC  = 3'd5,
      OP_DEC  = 3'd6,
      OP_PASS = 3'd7
   } alu_op_e;

   localparam int unsigned CF_POS = 0;
   localparam int unsigned PF_POS = 2;
   localparam int unsigned AF_POS = 4;
   localparam int unsigned ZF_POS = 6;
   localparam int unsigned SF_POS = 7;
   localparam int unsigned TF_POS = 8;
   localparam int unsigned IF_POS = 9;
   localparam int unsigned DF_POS = 10;
   localparam int unsigned OF_POS = 11;

   localparam int unsigned CTL_SEL_TF = 0;
   localparam int unsigned CTL_SEL_IF = 1;
   localparam int unsigned CTL_SEL_DF = 2;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic hcy;
      logic par;
      logic cry;
   } stat_flags_t;

   function automatic logic is_logic_op(input logic [2:0] op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic is_step_op(input logic [2:0] op);
      return (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NIB_W  = 4
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic              sub,
   input  logic              byte_mode,
   output logic [WORD_W-1:0] sum,
   output logic              cy_out,
   output logic              hc_out,
   output logic              ov_out
);
   logic [WORD_W-1:0] b_eff;
   logic [WORD_W:0]   chain;

   assign b_eff    = sub ? ~b : b;
   assign chain[0] = sub;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
      assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
   end

   logic top_out;
   logic top_in;

   assign top_out = byte_mode ? chain[BYTE_W]   : chain[WORD_W];
   assign top_in  = byte_mode ? chain[BYTE_W-1] : chain[WORD_W-1];

   // a subtract produces borrow as the inverted carry
   assign cy_out = top_out ^ sub;
   assign hc_out = chain[NIB_W] ^ sub;
   assign ov_out = top_out ^ top_in;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int unsigned WORD_W = 16
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [2:0]        op,
   output logic [WORD_W-1:0] y
);
   import alu_flag_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [WORD_W-1:0]       res,
   input  logic                    byte_mode,
   input  logic [2:0]              op,
   input  logic                    ar_cy,
   input  logic                    ar_hc,
   input  logic                    ar_ov,
   input  logic                    prev_cy,
   output alu_flag_pkg::stat_flags_t nxt
);
   import alu_flag_pkg::*;

   logic lo_zero;
   logic hi_zero;

   assign lo_zero = (res[BYTE_W-1:0] == '0);
   assign hi_zero = (res[WORD_W-1:BYTE_W] == '0);

   always_comb begin
      nxt.sgn = byte_mode ? res[BYTE_W-1] : res[WORD_W-1];
      nxt.zro = lo_zero & (byte_mode | hi_zero);
      nxt.par = ~(^res[BYTE_W-1:0]);
      if (is_logic_op(op)) begin
         nxt.cry = 1'b0;
         nxt.hcy = 1'b0;
         nxt.ovf = 1'b0;
      end else begin
         nxt.cry = is_step_op(op) ? prev_cy : ar_cy;
         nxt.hcy = ar_hc;
         nxt.ovf = ar_ov;
      end
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
   parameter int unsigned FLAG_W     = 16,
   parameter logic [15:0] UNUSED_VAL = 16'h0002
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stat_we,
   input  alu_flag_pkg::stat_flags_t  stat_d,
   input  logic                       ctl_we,
   input  logic [1:0]                 ctl_sel,
   input  logic                       ctl_val,
   output logic [FLAG_W-1:0]          flags
);
   import alu_flag_pkg::*;

   stat_flags_t stat_q;
   logic        tf_q;
   logic        if_q;
   logic        df_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else if (stat_we) begin
         stat_q <= stat_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tf_q <= 1'b0;
         if_q <= 1'b0;
         df_q <= 1'b0;
      end else if (ctl_we) begin
         if (ctl_sel == 2'(CTL_SEL_TF)) tf_q <= ctl_val;
         if (ctl_sel == 2'(CTL_SEL_IF)) if_q <= ctl_val;
         if (ctl_sel == 2'(CTL_SEL_DF)) df_q <= ctl_val;
      end
   end

   always_comb begin
      flags         = FLAG_W'(UNUSED_VAL);
      flags[CF_POS] = stat_q.cry;
      flags[PF_POS] = stat_q.par;
      flags[AF_POS] = stat_q.hcy;
      flags[ZF_POS] = stat_q.zro;
      flags[SF_POS] = stat_q.sgn;
      flags[OF_POS] = stat_q.ovf;
      flags[TF_POS] = tf_q;
      flags[IF_POS] = if_q;
      flags[DF_POS] = df_q;
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned FLAG_W     = 16,
   parameter logic [15:0] UNUSED_VAL = 16'h0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [2:0]        opcode,
   input  logic              byte_mode,
   input  logic              exec,
   input  logic              ctl_we,
   input  logic [1:0]        ctl_sel,
   input  logic              ctl_val,
   output logic [WORD_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   import alu_flag_pkg::*;

   localparam int unsigned HI_W = WORD_W - BYTE_W;

   if (WORD_W <= BYTE_W) begin : g_bad_word
      $error("WORD_W must exceed BYTE_W");
   end
   if (BYTE_W < 2 * NIB_W) begin : g_bad_byte
      $error("BYTE_W must hold two nibbles");
   end
   if (FLAG_W < OF_POS + 1) begin : g_bad_flag
      $error("FLAG_W too narrow for flag positions");
   end

   logic [WORD_W-1:0] addend;
   logic              do_sub;
   logic [WORD_W-1:0] ar_sum;
   logic              ar_cy;
   logic              ar_hc;
   logic              ar_ov;
   logic [WORD_W-1:0] lg_y;
   logic [WORD_W-1:0] raw;
   stat_flags_t       stat_nxt;
   logic              stat_we;

   assign addend = is_step_op(opcode) ? WORD_W'(1) : op_b;
   assign do_sub = (opcode == OP_SUB) || (opcode == OP_DEC);

   alu_addsub #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_addsub (
      .a         (op_a),
      .b         (addend),
      .sub       (do_sub),
      .byte_mode (byte_mode),
      .sum       (ar_sum),
      .cy_out    (ar_cy),
      .hc_out    (ar_hc),
      .ov_out    (ar_ov)
   );

   alu_logic #(.WORD_W(WORD_W)) u_logic (
      .a  (op_a),
      .b  (op_b),
      .op (opcode),
      .y  (lg_y)
   );

   always_comb begin
      if (is_logic_op(opcode))      raw = lg_y;
      else if (opcode == OP_PASS)   raw = op_a;
      else                          raw = ar_sum;
   end

   assign result = byte_mode ? {{HI_W{1'b0}}, raw[BYTE_W-1:0]} : raw;

   alu_status #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_status (
      .res       (result),
      .byte_mode (byte_mode),
      .op        (opcode),
      .ar_cy     (ar_cy),
      .ar_hc     (ar_hc),
      .ar_ov     (ar_ov),
      .prev_cy   (flags[CF_POS]),
      .nxt       (stat_nxt)
   );

   assign stat_we = exec && (opcode != OP_PASS);

   alu_flag_reg #(.FLAG_W(FLAG_W), .UNUSED_VAL(UNUSED_VAL)) u_freg (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_we (stat_we),
      .stat_d  (stat_nxt),
      .ctl_we  (ctl_we),
      .ctl_sel (ctl_sel),
      .ctl_val (ctl_val),
      .flags   (flags)
   );
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned FLAG_W     = 16,
   parameter logic [15:0] UNUSED_VAL = 16'h0002
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] op_a,
   input logic [2:0]        opcode,
   input logic              byte_mode,
   input logic              exec,
   input logic              ctl_we,
   input logic [1:0]        ctl_sel,
   input logic [WORD_W-1:0] result,
   input logic [FLAG_W-1:0] flags
);
   import alu_flag_pkg::*;

   localparam logic [FLAG_W-1:0] STAT_MASK = FLAG_W'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS)
                                             | (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));
   localparam logic [FLAG_W-1:0] CTL_MASK  = FLAG_W'((1 << TF_POS) | (1 << IF_POS) | (1 << DF_POS));
   localparam logic [FLAG_W-1:0] USED_MASK = STAT_MASK | CTL_MASK;

   logic loads;
   assign loads = exec && (opcode != OP_PASS);

   // R1
   a_r1_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      byte_mode |-> (result[WORD_W-1:BYTE_W] == '0));

   // R2
   a_r2_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && is_logic_op(opcode)) |=> (!flags[CF_POS] && !flags[AF_POS] && !flags[OF_POS]));

   // R3
   a_r3_step_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && is_step_op(opcode)) |=> (flags[CF_POS] == $past(flags[CF_POS])));

   // R5
   a_r5_sign_msb: assert property (@(posedge clk) disable iff (!rst_n)
      loads |=> (flags[SF_POS] == $past(byte_mode ? result[BYTE_W-1] : result[WORD_W-1])));

   // R5
   a_r5_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
      loads |=> (flags[ZF_POS] == ($past(result) == '0)));

   // R7
   a_r7_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
      loads |=> (flags[PF_POS] == ~(^$past(result[BYTE_W-1:0]))));

   // R8
   a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !loads |=> $stable(flags & STAT_MASK));

   // R8
   a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_PASS && !byte_mode) |-> (result == op_a));

   // R9
   a_r9_control_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we || ctl_sel == 2'd3) |=> $stable(flags & CTL_MASK));

   // R10
   a_r10_unused_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~USED_MASK) == (FLAG_W'(UNUSED_VAL) & ~USED_MASK)));
endmodule

bind alu_flag_unit alu_flag_chk #(
   .WORD_W(WORD_W), .BYTE_W(BYTE_W), .FLAG_W(FLAG_W), .UNUSED_VAL(UNUSED_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a      (op_a),
   .opcode    (opcode),
   .byte_mode (byte_mode),
   .exec      (exec),
   .ctl_we    (ctl_we),
   .ctl_sel   (ctl_sel),
   .result    (result),
   .flags     (flags)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [2:0]  opcode = '0;
   logic        byte_mode = 1'b0;
   logic        exec = 1'b0;
   logic        ctl_we = 1'b0;
   logic [1:0]  ctl_sel = '0;
   logic        ctl_val = 1'b0;
   logic [15:0] result;
   logic [15:0] flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // model state
   int m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
   int m_tf = 0, m_if = 0, m_df = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .byte_mode(byte_mode), .exec(exec), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
      .ctl_val(ctl_val), .result(result), .flags(flags)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h op=%0d byte=%0b)",
                  tag, what, act, exp, op_a, op_b, opcode, byte_mode);
      end
   endtask

   function automatic int model_flags();
      int f = 32'h0002;
      f |= m_cf << 0;  f |= m_pf << 2;  f |= m_af << 4;  f |= m_zf << 6;
      f |= m_sf << 7;  f |= m_tf << 8;  f |= m_if << 9;  f |= m_df << 10;
      f |= m_of << 11;
      return f;
   endfunction

   task automatic step(input logic [15:0] a, input logic [15:0] b, input int op,
                       input bit bm, input bit ex, input bit cwe, input int cs, input bit cv);
      int w, mask, msb, ai, bi, r, c, h, o, ones;
      @(negedge clk);
      op_a = a; op_b = b; opcode = 3'(op); byte_mode = bm; exec = ex;
      ctl_we = cwe; ctl_sel = 2'(cs); ctl_val = cv;
      w    = bm ? 8 : 16;
      mask = (1 << w) - 1;
      msb  = 1 << (w - 1);
      ai   = int'(a) & mask;
      bi   = (op == 5 || op == 6) ? 1 : (int'(b) & mask);
      c = 0; h = 0; o = 0;
      case (op)
         0, 5: begin
            r = (ai + bi) & mask;
            c = ((ai + bi) >> w) & 1;
            h = (((ai & 15) + (bi & 15)) > 15) ? 1 : 0;
            o = (((ai & msb) == (bi & msb)) && ((r & msb) != (ai & msb))) ? 1 : 0;
         end
         1, 6: begin
            r = (ai - bi) & mask;
            c = (ai < bi) ? 1 : 0;
            h = ((ai & 15) < (bi & 15)) ? 1 : 0;
            o = (((ai & msb) != (bi & msb)) && ((r & msb) != (ai & msb))) ? 1 : 0;
         end
         2: r = ai & bi;
         3: r = ai | bi;
         4: r = ai ^ bi;
         default: r = ai;
      endcase
      if (op == 5 || op == 6) c = m_cf;
      #1;
      check(op == 7 ? "R8" : ((op >= 2 && op <= 4) ? "R2" : "R1"), "result", int'(result), r);
      @(posedge clk);
      #1;
      if (ex && op != 7) begin
         ones = 0;
         for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
         m_cf = c; m_af = h; m_of = o;
         m_zf = (r == 0) ? 1 : 0;
         m_sf = ((r & msb) != 0) ? 1 : 0;
         m_pf = (ones % 2 == 0) ? 1 : 0;
      end
      if (cwe) begin
         if (cs == 0) m_tf = cv;
         if (cs == 1) m_if = cv;
         if (cs == 2) m_df = cv;
      end
      check("R3",  "CF",   int'(flags[0]),  m_cf);
      check("R7",  "PF",   int'(flags[2]),  m_pf);
      check("R6",  "AF",   int'(flags[4]),  m_af);
      check("R5",  "ZF",   int'(flags[6]),  m_zf);
      check("R5",  "SF",   int'(flags[7]),  m_sf);
      check("R4",  "OF",   int'(flags[11]), m_of);
      check("R9",  "ctl",  int'(flags[10:8]), (m_df << 2) | (m_if << 1) | m_tf);
      check("R10", "word", int'(flags), model_flags());
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10", "reset flags", int'(flags), 32'h0002);
      rst_n = 1'b1;

      // R1 R3 R4 R6: word add carry and overflow corners
      step(16'hFFFF, 16'h0001, 0, 0, 1, 0, 0, 0);
      step(16'h7FFF, 16'h0001, 0, 0, 1, 0, 0, 0);
      step(16'h000F, 16'h0001, 0, 0, 1, 0, 0, 0);
      // byte add: carry from bit 7, upper bits ignored
      step(16'hAB80, 16'h1280, 0, 1, 1, 0, 0, 0);
      step(16'h007F, 16'h0001, 0, 1, 1, 0, 0, 0);
      // subtract borrow and signed overflow
      step(16'h0000, 16'h0001, 1, 0, 1, 0, 0, 0);
      step(16'h8000, 16'h0001, 1, 0, 1, 0, 0, 0);
      step(16'h0010, 16'h0001, 1, 1, 1, 0, 0, 0);
      // R3: inc/dec keep CF
      step(16'hFFFF, 16'h0001, 0, 0, 1, 0, 0, 0);
      step(16'hFFFF, 16'h0000, 5, 0, 1, 0, 0, 0);
      step(16'h0000, 16'h0000, 6, 0, 1, 0, 0, 0);
      step(16'h00FF, 16'h0000, 5, 1, 1, 0, 0, 0);
      step(16'h0080, 16'h0000, 6, 1, 1, 0, 0, 0);
      // R2: logic clears CF/AF/OF
      step(16'hF0F0, 16'h0FF0, 2, 0, 1, 0, 0, 0);
      step(16'h1234, 16'h8001, 3, 0, 1, 0, 0, 0);
      step(16'hAAAA, 16'hAAAA, 4, 0, 1, 0, 0, 0);
      // R7: parity uses low byte only in word mode
      step(16'hFF00, 16'h0001, 3, 0, 1, 0, 0, 0);
      // R8: no exec, and pass opcode with exec
      step(16'h0001, 16'hFFFF, 0, 0, 1, 0, 0, 0);
      step(16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0);
      step(16'h0000, 16'h0000, 7, 0, 1, 0, 0, 0);
      step(16'h5A5A, 16'h0000, 7, 1, 1, 0, 0, 0);
      // R9: control writes, select 3 ignored, ALU leaves them
      step(16'h0000, 16'h0000, 7, 0, 0, 1, 0, 1);
      step(16'h0000, 16'h0000, 7, 0, 0, 1, 1, 1);
      step(16'h0000, 16'h0000, 7, 0, 0, 1, 2, 1);
      step(16'hFFFF, 16'hFFFF, 4, 0, 1, 1, 3, 0);
      step(16'h1111, 16'h2222, 0, 0, 1, 1, 1, 0);
      step(16'h0000, 16'h0000, 7, 0, 0, 1, 0, 0);

      // mixed pseudo-random traffic
      for (int i = 0; i < 600; i++) begin
         step(16'($urandom), 16'($urandom), int'($urandom % 8), bit'($urandom % 2),
              bit'(($urandom % 4) != 0), bit'(($urandom % 5) == 0), int'($urandom % 4),
              bit'($urandom % 2));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule